// File: doc/BRIEF.md
# Joinable Two-Channel Left-Aligned PWM

This block produces two left-aligned pulse-width-modulated outputs from a small synchronous register file. Each channel owns an 8-bit period, an 8-bit duty, a counter, an enable bit and a 3-bit rate field. The rate field picks a power-of-two slowdown of the system clock, drawn from one shared free-running divider. In separate mode the two channels are fully independent.

Setting the join bit fuses the pair into a single 16-bit generator. The even channel holds the upper byte of the counter, period and duty, and the odd channel holds the lower byte. The combined waveform drives only output 0. The odd channel's rate field clocks it, and the even channel's enable starts it. Period and duty values written by software are buffered and only take effect when the counter returns to zero, so a running waveform never shows a runt pulse. Software should change the join bit only while both channels are stopped. Clearing the counter just before enabling a channel gives a clean first period.

Top module: `pwm_duo`

## Requirements
- R1: Register map on the 3-bit address: 0 control (bit 7 join, bits 5:3 even-channel rate, bits 2:0 odd-channel rate, bit 6 reads 0), 1 enables (bit 0 even, bit 1 odd), 2/3 period even/odd, 4/5 duty even/odd, 6/7 counter even/odd. Reads are combinational. After reset every register reads 0 and both outputs are low.
- R2: With rate field value N, a running counter advances once every 2^N clock cycles, for N from 0 to 7.
- R3: In separate mode a running channel outputs high for duty×2^N cycles out of each period of period×2^N cycles, when 0 < duty < period. Its counter counts from 0 to period−1 and then wraps to 0.
- R4: A duty of 0 gives a constant low output. A duty greater than or equal to the period gives a constant high output.
- R5: A disabled channel in separate mode holds its output low and its counter at 0. The other channel keeps running unaffected.
- R6: Any write to a counter address clears that counter to 0, whatever data is written.
- R7: Written period and duty values reach the active comparison only when the counter is at 0: at a wrap, on a counter clear, or while the channel is stopped.
- R8: With join set, the pair acts as one 16-bit generator. Address 6 reads the counter's upper byte and address 7 its lower byte. Period and duty are {even, odd}. The waveform appears on output 0, and output 1 stays low.
- R9: With join set, the odd channel's rate field sets the 16-bit counter's rate, and the even channel's field has no effect.
- R10: With join set, only the even enable bit starts or stops the pair. The odd enable bit has no effect.
- R11: With join set, a write to either counter address clears the whole 16-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| pwm_out | output | 2 | PWM outputs; bit 0 carries the joined waveform |

## Verification
On every cycle, the assertions check four things. The divider never ticks on two cycles in a row for a nonzero rate. Each counter stays below its active period, in both modes. Active duty and period values change only while the counter sits at zero. Stopped or cleared counters read zero on the next cycle. The exact high time and period of the waveforms, for several rates, byte orders and duty values, can only be shown by the bench's edge-timing scoreboard. The same holds for the constant-level cases and for the register fields that must have no effect in joined mode.

// File: rtl/pwm_duo_pkg.sv
package pwm_duo_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_ENA   = 3'd1,
        RA_PER0  = 3'd2,
        RA_PER1  = 3'd3,
        RA_DUTY0 = 3'd4,
        RA_DUTY1 = 3'd5,
        RA_CNT0  = 3'd6,
        RA_CNT1  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/pwm_duo_regs.sv
module pwm_duo_regs
    import pwm_duo_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int SEL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CH_W-1:0]            wr_data,
    input  logic [1:0][CH_W-1:0]       cnt_view,
    output logic [CH_W-1:0]            rd_data,
    output logic                       join_o,
    output logic [1:0][SEL_W-1:0]      sel_o,
    output logic [1:0]                 en_o,
    output logic [1:0][CH_W-1:0]       per_o,
    output logic [1:0][CH_W-1:0]       duty_o,
    output logic [1:0]                 cnt_clr_o
);
    localparam int JOIN_POS = CH_W - 1;

    typedef struct packed {
        logic                  join_f;
        logic [1:0][SEL_W-1:0] sel;
        logic [1:0]            en;
        logic [1:0][CH_W-1:0]  per;
        logic [1:0][CH_W-1:0]  duty;
    } regs_t;

    regs_t r_q, r_d;
    reg_addr_e ra;

    always_comb begin
        ra        = reg_addr_e'(addr);
        r_d       = r_q;
        cnt_clr_o = '0;
        if (wr_en) begin
            unique case (ra)
                RA_CTRL: begin
                    r_d.join_f = wr_data[JOIN_POS];
                    r_d.sel[0] = wr_data[SEL_W +: SEL_W];
                    r_d.sel[1] = wr_data[0 +: SEL_W];
                end
                RA_ENA:   r_d.en      = wr_data[1:0];
                RA_PER0:  r_d.per[0]  = wr_data;
                RA_PER1:  r_d.per[1]  = wr_data;
                RA_DUTY0: r_d.duty[0] = wr_data;
                RA_DUTY1: r_d.duty[1] = wr_data;
                RA_CNT0:  cnt_clr_o[0] = 1'b1;
                RA_CNT1:  cnt_clr_o[1] = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (ra)
            RA_CTRL: begin
                rd_data[JOIN_POS]       = r_q.join_f;
                rd_data[SEL_W +: SEL_W] = r_q.sel[0];
                rd_data[0 +: SEL_W]     = r_q.sel[1];
            end
            RA_ENA:   rd_data[1:0] = r_q.en;
            RA_PER0:  rd_data = r_q.per[0];
            RA_PER1:  rd_data = r_q.per[1];
            RA_DUTY0: rd_data = r_q.duty[0];
            RA_DUTY1: rd_data = r_q.duty[1];
            RA_CNT0:  rd_data = cnt_view[0];
            RA_CNT1:  rd_data = cnt_view[1];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign join_o = r_q.join_f;
    assign sel_o  = r_q.sel;
    assign en_o   = r_q.en;
    assign per_o  = r_q.per;
    assign duty_o = r_q.duty;
endmodule

// File: rtl/pwm_duo_prescale.sv
module pwm_duo_prescale #(
    parameter int SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][SEL_W-1:0] sel,
    output logic [1:0]            tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q, div_d;

    always_comb div_d = div_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_tick
        logic [DIV_W-1:0] mask;
        always_comb begin
            mask    = ~({DIV_W{1'b1}} << sel[g]);
            tick[g] = &(div_q | ~mask);
        end

        // R2: a nonzero rate never yields ticks on back-to-back cycles
        p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[g] != '0 && tick[g]) |=> (!tick[g] || sel[g] != $past(sel[g])));
    end
endmodule

// File: rtl/pwm_duo_engine.sv
module pwm_duo_engine #(
    parameter int CH_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 join_i,
    input  logic [1:0]           en,
    input  logic [1:0]           tick,
    input  logic [1:0][CH_W-1:0] per,
    input  logic [1:0][CH_W-1:0] duty,
    input  logic [1:0]           clr,
    output logic [1:0][CH_W-1:0] cnt_o,
    output logic [1:0]           pwm
);
    localparam int JW = 2 * CH_W;

    typedef struct packed {
        logic [1:0][CH_W-1:0] cnt;
        logic [1:0][CH_W-1:0] per_a;
        logic [1:0][CH_W-1:0] duty_a;
        logic                 join_prev;
    } eng_t;

    eng_t q, d;
    logic            mode_chg;
    logic [JW:0]     inc_w;
    logic [CH_W:0]   inc_n [2];
    logic [JW-1:0]   cnt_w_q, per_w_q, duty_w_q;

    always_comb begin
        cnt_w_q  = {q.cnt[0], q.cnt[1]};
        per_w_q  = {q.per_a[0], q.per_a[1]};
        duty_w_q = {q.duty_a[0], q.duty_a[1]};
    end

    always_comb begin
        d           = q;
        d.join_prev = join_i;
        mode_chg    = join_i ^ q.join_prev;
        inc_w       = {1'b0, cnt_w_q} + 1'b1;
        for (int i = 0; i < 2; i++) inc_n[i] = {1'b0, q.cnt[i]} + 1'b1;

        if (join_i) begin
            if (!en[0] || clr[0] || clr[1] || mode_chg) begin
                d.cnt    = '0;
                d.per_a  = per;
                d.duty_a = duty;
            end else if (tick[1]) begin
                if (inc_w >= {1'b0, per_w_q}) begin
                    d.cnt    = '0;
                    d.per_a  = per;
                    d.duty_a = duty;
                end else begin
                    {d.cnt[0], d.cnt[1]} = inc_w[JW-1:0];
                end
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (!en[i] || clr[i] || mode_chg) begin
                    d.cnt[i]    = '0;
                    d.per_a[i]  = per[i];
                    d.duty_a[i] = duty[i];
                end else if (tick[i]) begin
                    if (inc_n[i] >= {1'b0, q.per_a[i]}) begin
                        d.cnt[i]    = '0;
                        d.per_a[i]  = per[i];
                        d.duty_a[i] = duty[i];
                    end else begin
                        d.cnt[i] = inc_n[i][CH_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (join_i) begin
            pwm[0] = en[0] && (cnt_w_q < duty_w_q);
            pwm[1] = 1'b0;
        end else begin
            for (int i = 0; i < 2; i++)
                pwm[i] = en[i] && (q.cnt[i] < q.duty_a[i]);
        end
    end

    assign cnt_o = q.cnt;

    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R3: in separate mode the counter stays below its active period
        p_cnt_below_per_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!join_i && !q.join_prev && en[g] && q.per_a[g] != '0)
                |-> (q.cnt[g] < q.per_a[g]));

        // R7: active duty/period only move while the counter sits at zero
        p_load_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(q.duty_a[g]) || !$stable(q.per_a[g])) |-> (q.cnt[g] == '0));

        // R5: a stopped channel reads a zero count on the next cycle
        p_stopped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!join_i && !en[g]) |=> (q.cnt[g] == '0));
    end

    // R8: joined counter stays below the joined active period
    p_wide_below_per_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (join_i && q.join_prev && en[0] && per_w_q != '0) |-> (cnt_w_q < per_w_q));

    // R10: with join set, clearing the even enable stops the whole pair
    p_join_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (join_i && !en[0]) |=> (q.cnt == '0));

    // R11: a counter write to either byte clears the whole wide counter
    p_join_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (join_i && (clr[0] || clr[1])) |=> (q.cnt == '0));
endmodule

// File: rtl/pwm_duo.sv
module pwm_duo
    import pwm_duo_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CH_W-1:0]   wr_data,
    output logic [CH_W-1:0]   rd_data,
    output logic [1:0]        pwm_out
);
    logic                  join_f;
    logic [1:0][SEL_W-1:0] sel;
    logic [1:0]            en;
    logic [1:0][CH_W-1:0]  per;
    logic [1:0][CH_W-1:0]  duty;
    logic [1:0]            cnt_clr;
    logic [1:0][CH_W-1:0]  cnt_view;
    logic [1:0]            tick;

    pwm_duo_regs #(.CH_W(CH_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .cnt_view  (cnt_view),
        .rd_data   (rd_data),
        .join_o    (join_f),
        .sel_o     (sel),
        .en_o      (en),
        .per_o     (per),
        .duty_o    (duty),
        .cnt_clr_o (cnt_clr)
    );

    pwm_duo_prescale #(.SEL_W(SEL_W)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .tick  (tick)
    );

    pwm_duo_engine #(.CH_W(CH_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .join_i (join_f),
        .en     (en),
        .tick   (tick),
        .per    (per),
        .duty   (duty),
        .clr    (cnt_clr),
        .cnt_o  (cnt_view),
        .pwm    (pwm_out)
    );
endmodule

// File: tb/tb_pwm_duo.sv
module tb_pwm_duo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] pwm_out;

    always #10 clk = ~clk;

    pwm_duo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    typedef struct {
        int    ch;
        int    hi;
        int    per;
        string tag;
    } wave_t;

    wave_t sbq[$];
    int    vecs = 0;
    int    fails = 0;
    int    cyc = 0;
    int    rise_t[2];
    int    fall_t[2];
    bit    fresh[2];
    logic [1:0] prev = 2'b00;

    function automatic void check(string tag, int got, int exp);
        vecs++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endfunction

    function automatic void finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endfunction

    // monitor: measures each waveform from its edges and pops the scoreboard
    always @(negedge clk) begin
        cyc++;
        for (int c = 0; c < 2; c++) begin
            if (pwm_out[c] && !prev[c]) begin
                if (sbq.size() > 0 && sbq[0].ch == c) begin
                    if (fresh[c]) fresh[c] = 1'b0;
                    else begin
                        check({sbq[0].tag, " high time"}, fall_t[c] - rise_t[c], sbq[0].hi);
                        check({sbq[0].tag, " period"}, cyc - rise_t[c], sbq[0].per);
                        void'(sbq.pop_front());
                    end
                end
                rise_t[c] = cyc;
            end
            if (!pwm_out[c] && prev[c]) fall_t[c] = cyc;
        end
        prev = pwm_out;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] dv);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = dv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk);
        addr = a;
        #1 check(tag, int'(rd_data), exp);
    endtask

    task automatic wr_peek(input logic [2:0] wa, input logic [7:0] wd,
                           input logic [2:0] pa, input int exp, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = wa; wr_data = wd;
        @(negedge clk);
        wr_en = 1'b0; addr = pa;
        #1 check(tag, int'(rd_data), exp);
    endtask

    task automatic expect_wave(input int ch, input int hi, input int per, input string tag);
        wave_t w;
        @(posedge clk);
        #1;
        w.ch = ch; w.hi = hi; w.per = per; w.tag = tag;
        fresh[ch] = 1'b1;
        sbq.push_back(w);
        for (int k = 0; k < 3 * per + 300 && sbq.size() > 0; k++) @(negedge clk);
        if (sbq.size() > 0) begin
            vecs++; fails++;
            $display("FAIL %s: actual no waveform expected period %0d", tag, per);
            sbq.delete();
        end
    endtask

    task automatic hold_check(input int ch, input logic val, input int n, input string tag);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1 if (pwm_out[ch] !== val) bad++;
        end
        vecs++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: actual %0d cycles off level, expected 0 (level %0d)", tag, bad, val);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and control field storage
        #1 check("R1 outputs after reset", int'(pwm_out), 0);
        for (int a = 0; a < 8; a++) rd_check(3'(a), 0, "R1 register reset");
        wr(3'd0, 8'hFF);
        rd_check(3'd0, 8'hBF, "R1 control readback");
        wr(3'd0, 8'h00);

        // R2/R3: two independent channels at different rates
        wr(3'd0, 8'h02);           // even rate 0, odd rate 2
        wr(3'd2, 8'd10); wr(3'd4, 8'd3);
        wr(3'd3, 8'd6);  wr(3'd5, 8'd4);
        wr(3'd1, 8'h03);
        repeat (60) @(negedge clk);
        expect_wave(0, 3, 10, "R3 even channel");
        expect_wave(1, 16, 24, "R2 odd channel rate 2");

        // R2: even channel at rate 3
        wr(3'd0, 8'h1A);
        repeat (200) @(negedge clk);
        expect_wave(0, 24, 80, "R2 even channel rate 3");

        // R7: buffered duty then period update
        wr(3'd0, 8'h02);
        repeat (30) @(negedge clk);
        wr(3'd4, 8'd7);
        repeat (30) @(negedge clk);
        expect_wave(0, 7, 10, "R7 new duty");
        wr(3'd2, 8'd20);
        repeat (40) @(negedge clk);
        expect_wave(0, 7, 20, "R7 new period");

        // R4: constant levels
        wr(3'd4, 8'd0);
        repeat (40) @(negedge clk);
        hold_check(0, 1'b0, 60, "R4 duty zero low");
        wr(3'd4, 8'd20);
        repeat (40) @(negedge clk);
        hold_check(0, 1'b1, 60, "R4 duty equals period high");

        // R5: stop the even channel, odd keeps going
        wr(3'd1, 8'h02);
        #1 check("R5 output low on disable", int'(pwm_out[0]), 0);
        hold_check(0, 1'b0, 50, "R5 stopped output");
        rd_check(3'd6, 0, "R5 stopped counter");
        expect_wave(1, 16, 24, "R5 odd channel unaffected");

        // R6: counter clear
        wr(3'd2, 8'd200); wr(3'd4, 8'd3);
        wr(3'd1, 8'h03);
        repeat (50) @(negedge clk);
        @(negedge clk);
        addr = 3'd6;
        #1 check("R6 counter running", int'(rd_data != 0), 1);
        wr_peek(3'd6, 8'hAA, 3'd6, 0, "R6 counter cleared");

        // R8/R9: joined 16-bit waveform, odd rate 1, even rate 7 ignored
        wr(3'd1, 8'h00);
        wr(3'd0, 8'hB9);
        wr(3'd2, 8'd1); wr(3'd3, 8'd4);
        wr(3'd4, 8'd0); wr(3'd5, 8'd100);
        wr(3'd1, 8'h01);
        repeat (600) @(negedge clk);
        expect_wave(0, 200, 520, "R8 R9 joined waveform");
        hold_check(1, 1'b0, 300, "R8 odd pin low when joined");

        // R10: only the even enable governs the pair
        wr(3'd1, 8'h02);
        hold_check(0, 1'b0, 100, "R10 odd enable alone");
        rd_check(3'd7, 0, "R10 counter held");
        wr(3'd1, 8'h03);
        repeat (600) @(negedge clk);
        expect_wave(0, 200, 520, "R10 odd enable no effect");

        // R8 byte order and R11 wide clear
        wr(3'd1, 8'h00);
        wr(3'd0, 8'hB8);
        wr(3'd2, 8'd3); wr(3'd3, 8'd0);
        wr(3'd4, 8'd1); wr(3'd5, 8'd0);
        wr(3'd1, 8'h01);
        repeat (300) @(negedge clk);
        rd_check(3'd6, 1, "R8 upper byte on even address");
        wr_peek(3'd7, 8'h55, 3'd6, 0, "R11 upper byte cleared by odd write");

        finish_run();
    end
endmodule